// File: doc/BRIEF.md
# DMA Request Activation and End-of-Transfer Front End

This block sits in front of one DMA channel engine. It takes an active-low external request pin and an internal interrupt request and turns them into single-cycle start pulses for the engine. A mode input picks how the pin is interpreted. In edge-sense mode, a three-state machine arms on a low level, waits until the channel can transfer, and then blocks until the pin goes high again. In level-sense mode, a start is issued on every cycle in which the pin is low and the channel can transfer.

The block also drives the active-low end-of-transfer output for the final transfer cycle. That output is held high when the final cycle is purely internal and a buffered external write is running at the same time. It goes low whenever the source or the destination of the transfer is external.

The pin passes through a synchronizer clocked by the channel clock. The enable input and the mode input are each registered once. Request evaluation never waits on the buffered-write flag.

Top module: `dma_req_front`

## Requirements
- R1: While reset is held, and on the first cycle after reset, `start_o` is 0 and `tend_n_o` is 1.
- R2: In edge mode (`edge_mode_i`=1) with the block enabled and `xfer_ok_i`=1, driving `req_n_i` low gives exactly one `start_o` pulse. The pulse lasts one cycle and is high after the fourth rising edge that follows the change: two synchronizer stages, the move from idle to pending, and the move from pending to blocked.
- R3: In edge mode a pending request waits while `xfer_ok_i`=0. The start pulse follows the first rising edge at which `xfer_ok_i`=1.
- R4: After an edge-mode start, no further start occurs while the pin stays low. Once the synchronized pin has been high, a new low level arms the machine again.
- R5: A pin low level that is already present when `enable_i` rises is accepted. The start follows the third rising edge after the enable changes.
- R6: In level mode (`edge_mode_i`=0) a start is issued on every cycle in which the synchronized pin is low and `xfer_ok_i` is 1.
- R7: An internal request (`irq_req_i`=1) gives a start on each cycle in which the block is enabled and `xfer_ok_i`=1, in either mode. A request that is present before `enable_i` rises is accepted on the second rising edge after the rise.
- R8: Dropping `enable_i` discards a pending request. If the block is enabled again while the pin is high, no start is issued.
- R9: `tend_n_o` is 0 in any cycle where `last_cycle_i`=1 and at least one of `src_ext_i` or `dst_ext_i` is 1. It is 1 whenever `last_cycle_i`=0.
- R10: When `last_cycle_i`=1 and both addresses are internal, `tend_n_o` is 1 if `wbuf_busy_i`=1 and 0 if `wbuf_busy_i`=0.
- R11: `wbuf_busy_i` has no effect on the timing or the count of start pulses.
- R12: No start is issued in a cycle after one in which `xfer_ok_i` was 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Channel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_n_i | input | 1 | External request pin, active low, asynchronous |
| irq_req_i | input | 1 | Internal interrupt request, active high |
| enable_i | input | 1 | Transfer enable (registered) |
| edge_mode_i | input | 1 | 1 = edge sensing, 0 = level sensing (registered) |
| xfer_ok_i | input | 1 | The channel engine can start a transfer |
| last_cycle_i | input | 1 | The current bus cycle is the final transfer cycle |
| src_ext_i | input | 1 | Source address is external |
| dst_ext_i | input | 1 | Destination address is external |
| wbuf_busy_i | input | 1 | A buffered external write is in progress |
| start_o | output | 1 | Transfer-start pulse to the engine |
| tend_n_o | output | 1 | End of transfer, active low |

## Verification
The bench goes after the edge machine's arming rule:
- A pin held low across the enable must still start a transfer. A design that waited for a true falling edge would stay silent.
- A pin held low after a start must not start again. A design without the blocked state would issue a new start every cycle.

A request left pending when the channel is disabled must vanish. A design that kept it would fire as soon as the channel is enabled again.

For the end-of-transfer output, the bench walks the combinations of the address and buffer flags. A design that ignored the suppression rule would pulse `tend_n_o` during internal-only cycles that overlap a buffered write. A design that stalled on the write flag would lose or delay start pulses.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_BLOCK = 2'd2
  } arm_state_e;
endpackage

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= RST_VAL;
    else         chain_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= RST_VAL;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dma_req_arm_fsm.sv
module dma_req_arm_fsm
  import dma_req_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       edge_i,
  input  logic       pin_low_i,
  input  logic       xfer_ok_i,
  output logic       go_o,
  output arm_state_e state_o
);
  arm_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    go_o = 1'b0;
    if (!en_i || !edge_i) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (pin_low_i) st_d = ST_PEND;
        ST_PEND:  if (xfer_ok_i) begin
                    st_d = ST_BLOCK;
                    go_o = 1'b1;
                  end
        ST_BLOCK: if (!pin_low_i) st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/dma_req_tend.sv
module dma_req_tend (
  input  logic last_cycle_i,
  input  logic src_ext_i,
  input  logic dst_ext_i,
  input  logic wbuf_busy_i,
  output logic tend_n_o
);
  logic any_ext, hidden;

  assign any_ext  = src_ext_i | dst_ext_i;
  // internal-only final cycle hidden behind a buffered external write
  assign hidden   = !any_ext && wbuf_busy_i;
  assign tend_n_o = !(last_cycle_i && !hidden);
endmodule

// File: rtl/dma_req_front.sv
module dma_req_front
  import dma_req_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_n_i,
  input  logic irq_req_i,
  input  logic enable_i,
  input  logic edge_mode_i,
  input  logic xfer_ok_i,
  input  logic last_cycle_i,
  input  logic src_ext_i,
  input  logic dst_ext_i,
  input  logic wbuf_busy_i,
  output logic start_o,
  output logic tend_n_o
);
  logic       enable_q, mode_q;
  logic       pin_s, pin_low_s;
  logic       fsm_go, pin_req, start_q;
  arm_state_e edge_st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= 1'b0;
      mode_q   <= 1'b1;
    end else begin
      enable_q <= enable_i;
      mode_q   <= edge_mode_i;
    end
  end

  dma_req_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_n_i),
    .q_o   (pin_s)
  );
  assign pin_low_s = !pin_s;

  dma_req_arm_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (enable_q),
    .edge_i   (mode_q),
    .pin_low_i(pin_low_s),
    .xfer_ok_i(xfer_ok_i),
    .go_o     (fsm_go),
    .state_o  (edge_st)
  );

  assign pin_req = mode_q ? fsm_go : (pin_low_s && xfer_ok_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b0;
    else         start_q <= enable_q && (pin_req || (irq_req_i && xfer_ok_i));
  end
  assign start_o = start_q;

  dma_req_tend u_tend (
    .last_cycle_i(last_cycle_i),
    .src_ext_i   (src_ext_i),
    .dst_ext_i   (dst_ext_i),
    .wbuf_busy_i (wbuf_busy_i),
    .tend_n_o    (tend_n_o)
  );
endmodule

// File: rtl/dma_req_front_chk.sv
module dma_req_front_chk
  import dma_req_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       enable_i,
  input logic       xfer_ok_i,
  input logic       last_cycle_i,
  input logic       src_ext_i,
  input logic       dst_ext_i,
  input logic       start_o,
  input logic       tend_n_o,
  input logic       enable_q,
  input logic       mode_q,
  input arm_state_e edge_st
);
  assert_start_pend_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_st == ST_PEND && xfer_ok_i && enable_q && mode_q) |=> start_o);

  assert_block_no_pend_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_st == ST_BLOCK) |=> (edge_st != ST_PEND));

  assert_disable_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_q |=> (edge_st == ST_IDLE && !start_o));

  assert_tend_ext_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_cycle_i && (src_ext_i || dst_ext_i)) |-> !tend_n_o);

  assert_tend_only_last_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tend_n_o |-> last_cycle_i);

  assert_start_needs_ok_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(xfer_ok_i));

  assert_start_needs_en_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(enable_q));
endmodule

bind dma_req_front dma_req_front_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .enable_i    (enable_i),
  .xfer_ok_i   (xfer_ok_i),
  .last_cycle_i(last_cycle_i),
  .src_ext_i   (src_ext_i),
  .dst_ext_i   (dst_ext_i),
  .start_o     (start_o),
  .tend_n_o    (tend_n_o),
  .enable_q    (enable_q),
  .mode_q      (mode_q),
  .edge_st     (edge_st)
);

// File: tb/sim_dma_req_front.sv
module sim_dma_req_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_n = 1'b1, irq = 1'b0, en = 1'b0, edge_m = 1'b1, ok = 1'b1;
  logic last = 1'b0, src_x = 1'b0, dst_x = 1'b0, wb = 1'b0;
  logic start, tend_n;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dma_req_front u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_n_i(req_n), .irq_req_i(irq),
    .enable_i(en), .edge_mode_i(edge_m), .xfer_ok_i(ok),
    .last_cycle_i(last), .src_ext_i(src_x), .dst_ext_i(dst_x),
    .wbuf_busy_i(wb), .start_o(start), .tend_n_o(tend_n)
  );

  // {last, src_ext, dst_ext, wbuf_busy, expected tend_n}
  localparam logic [4:0] TEND_VEC [10] = '{
    5'b0000_1, 5'b0111_1, 5'b1100_0, 5'b1010_0, 5'b1110_0,
    5'b1101_0, 5'b1011_0, 5'b1111_0, 5'b1000_0, 5'b1001_1
  };

  task automatic check(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic count_starts(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      c += int'(start);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int c;
    #3;
    check(start, 0, "R1 start in reset");
    check(tend_n, 1, "R1 tend in reset");
    tick(2);
    rst_n = 1'b1;
    tick(1);
    check(start, 0, "R1 start after reset");
    check(tend_n, 1, "R1 tend after reset");

    // end-of-transfer vector table
    foreach (TEND_VEC[i]) begin
      {last, src_x, dst_x, wb} = TEND_VEC[i][4:1];
      #1;
      check(tend_n, TEND_VEC[i][0], (last && !src_x && !dst_x) ? "R10 tend vector" : "R9 tend vector");
    end
    {last, src_x, dst_x, wb} = 4'b0000;

    // R2: edge mode, single pulse at fixed latency
    en = 1'b1; tick(3);
    req_n = 1'b0;
    tick(3); check(start, 0, "R2 before start");
    tick(1); check(start, 1, "R2 start pulse");
    tick(1); check(start, 0, "R2 pulse width");
    // R4: blocked while low, rearm after high
    count_starts(10, c); check(c, 0, "R4 no restart while low");
    req_n = 1'b1; tick(4);
    req_n = 1'b0; count_starts(8, c); check(c, 1, "R4 rearm after high");

    // R3: pending waits for xfer_ok
    req_n = 1'b1; tick(4);
    ok = 1'b0; req_n = 1'b0;
    count_starts(8, c); check(c, 0, "R3 held while not ok");
    ok = 1'b1;
    tick(1); check(start, 1, "R3 start on ok");
    tick(1); check(start, 0, "R3 single pulse");

    // R5: low level present before enable
    en = 1'b0; tick(3);
    en = 1'b1;
    tick(2); check(start, 0, "R5 before start");
    tick(1); check(start, 1, "R5 start from existing low");

    // R8: disable discards pending
    req_n = 1'b1; tick(4);
    ok = 1'b0; req_n = 1'b0; tick(6);
    en = 1'b0; tick(3);
    req_n = 1'b1; tick(4);
    en = 1'b1; ok = 1'b1;
    count_starts(8, c); check(c, 0, "R8 pending discarded");

    // R6 / R11 / R12: level mode
    edge_m = 1'b0; req_n = 1'b0; tick(4);
    count_starts(10, c); check(c, 10, "R6 level every cycle");
    ok = 1'b0; tick(1);
    count_starts(5, c); check(c, 0, "R12 no start without ok");
    ok = 1'b1; wb = 1'b1; tick(1);
    count_starts(5, c); check(c, 5, "R11 level with buffered write");
    req_n = 1'b1; tick(3);
    count_starts(4, c); check(c, 0, "R6 no start when pin high");

    // R11 in edge mode
    edge_m = 1'b1; tick(2);
    req_n = 1'b0;
    tick(3); check(start, 0, "R11 edge before start");
    tick(1); check(start, 1, "R11 edge start with buffered write");
    wb = 1'b0; req_n = 1'b1; tick(4);

    // R7: internal request before enable, then continuous
    en = 1'b0; tick(2);
    irq = 1'b1;
    tick(3); check(start, 0, "R7 no start while disabled");
    en = 1'b1;
    tick(1); check(start, 0, "R7 before start");
    tick(1); check(start, 1, "R7 irq start");
    count_starts(5, c); check(c, 5, "R7 irq each cycle edge mode");
    edge_m = 1'b0; tick(1);
    count_starts(5, c); check(c, 5, "R7 irq each cycle level mode");
    irq = 1'b0; tick(1);
    count_starts(4, c); check(c, 0, "R7 irq removed");

    finish_run();
  end
endmodule